// File: doc/BRIEF.md
# UART Character Buffer With Single-Slot Mode

This block is the character store that sits between a UART's serial engine and the host side, one instance per direction. It holds up to sixteen words. On the receive side each word is nine bits wide: eight character bits plus a tag bit that flags a parity fault for that character. Words leave in the order they arrived. The oldest word is always visible on the read port while the buffer holds data.

A mode input picks how much of the store is in use. With the input high, all sixteen slots are available and the service request uses a half-way mark. With the input low, only a single slot is available and a service request is raised for every character. A parameter picks the request flavour. The receive flavour asks for service when enough data is waiting. The transmit flavour asks for service when enough room is free. Any change of the mode input empties the buffer, so no word can sit beyond the single-slot limit.

A push into a full buffer is dropped and reported by a one-cycle overflow pulse. A pop from an empty buffer is dropped and reported by a one-cycle underflow pulse. Pushing and popping together on a buffer that holds data replaces the oldest word, and the occupancy stays the same.

Top module: `uart_fifo_buf`

## Requirements
- R1: With the mode input at 1, sixteen pushes are accepted; `full` rises exactly when `level` reaches 16, and `level` never exceeds 16.
- R2: With the mode input at 0, the buffer holds at most one word; `full` is 1 whenever `level` is 1.
- R3: Words are popped in arrival order with all nine bits intact, bit 8 (the parity-fault tag) included; `popData` shows the oldest word whenever `empty` is 0.
- R4: In the receive flavour (IS_RX=1), `irq` is 1 while `level` is at least 8 in sixteen-slot mode, and while `level` is at least 1 in single-slot mode.
- R5: In the transmit flavour (IS_RX=0), `irq` is 1 while free space (capacity minus `level`) is at least 8 in sixteen-slot mode, and while at least 1 slot is free in single-slot mode.
- R6: A push while `full` is 1 without a pop is ignored: `level` and the stored words do not change, and `overflow` is 1 for the single cycle after that clock edge.
- R7: A pop while `empty` is 1 is ignored, and `underflow` is 1 for the single cycle after that edge. A push in the same cycle is still accepted.
- R8: A push and a pop in the same cycle on a buffer that holds data leave `level` unchanged. This includes a full buffer. The popped word is the oldest one and the pushed word becomes the newest.
- R9: When the mode input differs from the mode in force, the next edge empties the buffer and adopts the new mode. A push or pop in that cycle is ignored and raises no overflow or underflow.
- R10: After reset, `empty` is 1, `full` is 0, `level` is 0, `overflow` and `underflow` are 0, and sixteen-slot mode is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| fullMode | input | 1 | 1 = sixteen slots in use, 0 = single slot |
| push | input | 1 | Write request for `pushData` |
| pushData | input | DATA_W (9) | Word to store; bit 8 is the parity-fault tag on receive |
| pop | input | 1 | Remove the oldest word |
| popData | output | DATA_W (9) | Oldest stored word |
| full | output | 1 | Buffer at capacity for the current mode |
| empty | output | 1 | No word stored |
| level | output | $clog2(DEPTH+1) (5) | Number of stored words |
| overflow | output | 1 | One-cycle pulse after a dropped push |
| underflow | output | 1 | One-cycle pulse after a dropped pop |
| irq | output | 1 | Service request, receive or transmit flavour |

## Verification
The hardest states to reach are the mode switch with data still stored and a simultaneous push and pop on an already full buffer. A full buffer needs sixteen accepted pushes first. The stimulus therefore fills the store, checks both threshold crossings on the way up, and then pushes and pops together at the top. It then leaves exactly one word behind and flips the mode input in a cycle that also carries a push, so the flush and the suppression of that push can be seen at the ports. Two instances share the stimulus, one of each request flavour, so both threshold rules are judged on identical occupancy.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Strobes issued by the control half to the storage half each cycle.
  typedef struct packed {
    logic wrEn;        // store pushData at the write slot
    logic rdEn;        // retire the oldest word
    logic flush;       // discard everything, rewind both slots
    logic singleMode;  // only slot zero is in use
  } fifoStrobe_t;

endpackage

// File: rtl/uart_fifo_dpath.sv
module uart_fifo_dpath
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p,
                                               input logic single);
    if (single)            return '0;
    else if (p == LAST_SLOT) return '0;
    else                   return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn) wrPtr <= advance(wrPtr, strobe.singleMode);
      if (strobe.rdEn) rdPtr <= advance(rdPtr, strobe.singleMode);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) store[wrPtr] <= wrData;
  end

  assign rdData = store[rdPtr];

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int HALF       = 8,
  parameter int CNT_W      = 5,
  parameter bit IS_RX      = 1'b1,
  parameter bit RESET_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fullMode,
  input  logic             push,
  input  logic             pop,
  output fifoStrobe_t      strobe,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow,
  output logic             irq,
  output logic             activeMode
);

  logic             modeQ;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] capacity;
  logic             modeChange;
  logic             popOk;
  logic             pushOk;
  logic             isFull;
  logic             isEmpty;

  assign modeChange = fullMode != modeQ;
  assign capacity   = modeQ ? CNT_W'(DEPTH) : CNT_W'(1);
  assign isFull     = count == capacity;
  assign isEmpty    = count == '0;
  assign popOk      = pop & ~isEmpty & ~modeChange;
  assign pushOk     = push & (~isFull | popOk) & ~modeChange;

  always_comb begin
    strobe            = '0;
    strobe.wrEn       = pushOk;
    strobe.rdEn       = popOk;
    strobe.flush      = modeChange;
    strobe.singleMode = ~modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= RESET_MODE;
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      modeQ     <= fullMode;
      overflow  <= push & isFull & ~popOk & ~modeChange;
      underflow <= pop & isEmpty & ~modeChange;
      if (modeChange)          count <= '0;
      else if (pushOk & ~popOk) count <= count + 1'b1;
      else if (popOk & ~pushOk) count <= count - 1'b1;
    end
  end

  generate
    if (IS_RX) begin : g_rxReq
      assign irq = modeQ ? (count >= CNT_W'(HALF)) : (count != '0);
    end else begin : g_txReq
      logic [CNT_W-1:0] freeSlots;
      assign freeSlots = capacity - count;
      assign irq = modeQ ? (freeSlots >= CNT_W'(HALF)) : (freeSlots != '0);
    end
  endgenerate

  assign level      = count;
  assign full       = isFull;
  assign empty      = isEmpty;
  assign activeMode = modeQ;

endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf
  import uart_fifo_pkg::*;
#(
  parameter int DATA_W     = 9,
  parameter int DEPTH      = 16,
  parameter bit IS_RX      = 1'b1,
  parameter bit RESET_MODE = 1'b1,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int HALF      = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fullMode,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level,
  output logic              overflow,
  output logic              underflow,
  output logic              irq
);

  fifoStrobe_t strobe;
  logic        activeMode;

  uart_fifo_ctrl #(
    .DEPTH(DEPTH), .HALF(HALF), .CNT_W(CNT_W),
    .IS_RX(IS_RX), .RESET_MODE(RESET_MODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fullMode(fullMode), .push(push), .pop(pop),
    .strobe(strobe), .level(level), .full(full), .empty(empty),
    .overflow(overflow), .underflow(underflow), .irq(irq),
    .activeMode(activeMode)
  );

  uart_fifo_dpath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(pushData), .rdData(popData)
  );

endmodule

// File: rtl/uart_fifo_buf_chk.sv
module uart_fifo_buf_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fullMode,
  input logic             push,
  input logic             pop,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] level,
  input logic             overflow,
  input logic             underflow,
  input logic             activeMode
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode && full) |-> (level == CNT_W'(DEPTH)));  // R1

  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (!activeMode && !empty) |-> full);  // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && full && fullMode == activeMode) |=> (overflow && $stable(level)));  // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !push && empty && fullMode == activeMode) |=> (underflow && $stable(level)));  // R7

  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !empty && fullMode == activeMode) |=> $stable(level));  // R8

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (fullMode != activeMode) |=> (empty && !overflow && !underflow));  // R9

endmodule

bind uart_fifo_buf uart_fifo_buf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .fullMode(fullMode), .push(push), .pop(pop),
  .full(full), .empty(empty), .level(level), .overflow(overflow),
  .underflow(underflow), .activeMode(activeMode)
);

// File: tb/sim_uart_fifo_buf.sv
module sim_uart_fifo_buf;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 9;
  localparam int DEPTH      = 16;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              fullMode = 1'b1;
  logic              push = 1'b0;
  logic              pop = 1'b0;
  logic [DATA_W-1:0] pushData = '0;

  logic [DATA_W-1:0] popData, popDataTx;
  logic              full, empty, overflow, underflow, irqRx;
  logic              fullTx, emptyTx, overflowTx, underflowTx, irqTx;
  logic [CNT_W-1:0]  level, levelTx;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IS_RX(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .fullMode(fullMode), .push(push),
    .pushData(pushData), .pop(pop), .popData(popData), .full(full),
    .empty(empty), .level(level), .overflow(overflow),
    .underflow(underflow), .irq(irqRx)
  );

  uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IS_RX(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .fullMode(fullMode), .push(push),
    .pushData(pushData), .pop(pop), .popData(popDataTx), .full(fullTx),
    .empty(emptyTx), .level(levelTx), .overflow(overflowTx),
    .underflow(underflowTx), .irq(irqTx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, cross one rising edge, return at the next falling edge.
  task automatic step(input logic p, input logic q, input logic [DATA_W-1:0] d);
    push = p; pop = q; pushData = d;
    @(posedge clk);
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  function automatic logic [DATA_W-1:0] word(input int i);
    return {i[0], 8'(8'hA0 + i)};
  endfunction

  task automatic t_reset();
    chk("R10 empty", 32'(empty), 1);
    chk("R10 full", 32'(full), 0);
    chk("R10 level", 32'(level), 0);
    chk("R10 overflow", 32'(overflow), 0);
    chk("R10 underflow", 32'(underflow), 0);
    chk("R4 rx irq idle", 32'(irqRx), 0);
    chk("R5 tx irq idle", 32'(irqTx), 1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, word(i));
      chk("R1 level rising", 32'(level), 32'(i + 1));
      chk("R4 rx threshold", 32'(irqRx), 32'((i + 1) >= 8));
      chk("R5 tx threshold", 32'(irqTx), 32'((DEPTH - i - 1) >= 8));
      chk("R1 full flag", 32'(full), 32'(i == DEPTH - 1));
    end
    step(1'b1, 1'b0, 9'h1FF);
    chk("R6 overflow pulse", 32'(overflow), 1);
    chk("R6 level held", 32'(level), DEPTH);
    step(1'b0, 1'b0, '0);
    chk("R6 pulse ends", 32'(overflow), 0);
    chk("R6 head kept", 32'(popData), 32'(word(0)));
  endtask

  task automatic t_drain();
    // Push and pop together on a full buffer.
    step(1'b1, 1'b1, 9'h155);
    chk("R8 level full", 32'(level), DEPTH);
    chk("R8 still full", 32'(full), 1);
    for (int i = 1; i <= DEPTH; i++) begin
      chk("R3 order", 32'(popData), (i < DEPTH) ? 32'(word(i)) : 32'h155);
      step(1'b0, 1'b1, '0);
    end
    chk("R3 drained", 32'(empty), 1);
    step(1'b0, 1'b1, '0);
    chk("R7 underflow pulse", 32'(underflow), 1);
    chk("R7 level zero", 32'(level), 0);
    step(1'b1, 1'b1, 9'h1C3);
    chk("R7 pop on empty flagged", 32'(underflow), 1);
    chk("R7 push still taken", 32'(level), 1);
    chk("R3 tag bit kept", 32'(popData), 32'h1C3);
  endtask

  task automatic t_single();
    // One word stored; switch mode while also pushing.
    fullMode = 1'b0;
    step(1'b1, 1'b0, 9'h0AA);
    chk("R9 flushed", 32'(empty), 1);
    chk("R9 level", 32'(level), 0);
    chk("R9 no overflow", 32'(overflow), 0);
    chk("R5 single idle tx", 32'(irqTx), 1);
    chk("R4 single idle rx", 32'(irqRx), 0);
    step(1'b1, 1'b0, 9'h111);
    chk("R2 full after one", 32'(full), 1);
    chk("R2 level one", 32'(level), 1);
    chk("R4 single rx", 32'(irqRx), 1);
    chk("R5 single tx", 32'(irqTx), 0);
    step(1'b1, 1'b0, 9'h022);
    chk("R6 single overflow", 32'(overflow), 1);
    chk("R2 capped", 32'(level), 1);
    chk("R6 word kept", 32'(popData), 32'h111);
    step(1'b1, 1'b1, 9'h133);
    chk("R8 single level", 32'(level), 1);
    chk("R8 single replace", 32'(popData), 32'h133);
    step(1'b0, 1'b1, '0);
    chk("R2 emptied", 32'(empty), 1);
    chk("R5 tx back", 32'(irqTx), 1);
    step(1'b1, 1'b0, 9'h044);
    fullMode = 1'b1;
    step(1'b0, 1'b1, '0);
    chk("R9 back to full flush", 32'(level), 0);
    chk("R9 no underflow", 32'(underflow), 0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, word(i));
    chk("R1 multi after switch", 32'(level), 3);
    chk("R1 not full", 32'(full), 0);
    chk("R3 head after switch", 32'(popData), 32'(word(0)));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL R10 watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_drain();
    t_single();
    summary();
    $finish;
  end

endmodule